// File: doc/BRIEF.md
# Triple Edge-Triggered Storage Cell with Shared Clock and Master Overrides

This block holds three independent one-bit values, each presented on a true output and a complementary output. Every element has a private data input, a private clock, a private force-high and a private force-low input. A common clock and a pair of master force-high and force-low inputs reach all three elements together. An element loads when the OR of its private clock and the common clock goes from low to high. The value it loads is the data that was present while both clocks were still low.

All pins are treated as slow asynchronous signals. Each pin passes through a two-stage synchroniser on a fast system clock. Rising edges are found on the synchronised combined clock. The force inputs outrank any clock activity. The master versions are ORed with the per-element versions.

Forcing an element high and low at the same time has no defined meaning in the plain storage cell. Here that case drives both outputs high and raises a per-element conflict flag. The stored value is left high when the conflict is released.

Top module: `tri_store`

## Requirements
- R1: While `rst_n` is low at a system clock edge, all elements clear: `q_o`=000, `qn_o`=111, `conflict_o`=000.
- R2: With no force active, a low-to-high change of (`cp_i[n]` OR `cp_all_i`) loads element n with the `d_i[n]` value that was sampled while both of those clocks were low. Elements whose combined clock does not rise are not loaded.
- R3: A rising edge on one of an element's two clocks while the other is already high does not load that element.
- R4: With no force active and no qualifying rising edge, `q_o[n]` holds its value, whatever `d_i` does.
- R5: When the effective set (`set_i[n]` OR `set_all_i`) is high and the effective clear (`clr_i[n]` OR `clr_all_i`) is low, `q_o[n]` goes to 1.
- R6: When the effective clear is high and the effective set is low, `q_o[n]` goes to 0.
- R7: When both the effective set and the effective clear are high, `q_o[n]` and `qn_o[n]` are both 1 and `conflict_o[n]` is 1. When the forces are released without a clock edge, `q_o[n]` stays 1 and `conflict_o[n]` returns to 0.
- R8: A force active during a clock edge wins over the edge. Releasing the force while the clock stays high loads nothing. The next qualifying rising edge loads data again.
- R9: When `conflict_o[n]` is 0, `qn_o[n]` is the inverse of `q_o[n]`.
- R10: A pin change that is stable before system clock edge k is first visible at the outputs after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| d_i | input | 3 | Per-element data |
| cp_i | input | 3 | Per-element clock |
| set_i | input | 3 | Per-element force-high |
| clr_i | input | 3 | Per-element force-low |
| cp_all_i | input | 1 | Clock shared by all elements |
| set_all_i | input | 1 | Force-high shared by all elements |
| clr_all_i | input | 1 | Force-low shared by all elements |
| q_o | output | 3 | True outputs |
| qn_o | output | 3 | Complement outputs |
| conflict_o | output | 3 | Per-element simultaneous force flag |

## Verification
The assertions check the per-cycle rules of each element on every cycle: the force outcomes, holding when nothing is active, the conflict outputs, and the complement relation. The bench scenarios cover behaviour that spans several pin changes. These are overlapping clock pulses where the second rise must not load, a force held across a clock edge and released while the clock stays high, and the exact three-edge latency from pin to output. The bench also sweeps every data pattern through both clock sources and every force combination on each element, so that the master inputs are seen to reach the other elements as well.

// File: rtl/tri_store_pkg.sv
// Package: shared types for the triple storage block.
// Assumes: consumers decode one action per element per cycle.
package tri_store_pkg;
    // Per-element next-state action, ordered by priority (conflict highest).
    typedef enum logic [2:0] {
        ACT_HOLD     = 3'd0,
        ACT_LOAD     = 3'd1,
        ACT_CLR      = 3'd2,
        ACT_SET      = 3'd3,
        ACT_CONFLICT = 3'd4
    } cell_act_t;
endpackage

// File: rtl/tri_store_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes: each bit is independent; no bus coherency across bits is needed.
module tri_store_sync #(
    parameter int WIDTH  = 15,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= din;
            end
        end else begin : g_next
            // Later stages: shift the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/tri_store_cell.sv
// Module: one storage element with a master stage, edge detection on the
// OR of two clocks, and force-high / force-low overrides.
// Assumes: all inputs are already synchronised to clk.
module tri_store_cell
    import tri_store_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic cp_own,
    input  logic cp_shared,
    input  logic set_own,
    input  logic set_shared,
    input  logic clr_own,
    input  logic clr_shared,
    output logic q,
    output logic qn,
    output logic conflict
);
    logic      comb_clk, comb_prev, rise;
    logic      eff_set, eff_clr;
    logic      master_r, q_r, conf_r;
    cell_act_t act;

    assign comb_clk = cp_own | cp_shared;
    assign rise     = comb_clk & ~comb_prev;
    assign eff_set  = set_own | set_shared;
    assign eff_clr  = clr_own | clr_shared;

    // Pick this cycle's action; forces outrank the clock.
    always_comb begin
        if (eff_set && eff_clr) act = ACT_CONFLICT;
        else if (eff_set)       act = ACT_SET;
        else if (eff_clr)       act = ACT_CLR;
        else if (rise)          act = ACT_LOAD;
        else                    act = ACT_HOLD;
    end

    // Remember the last combined clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) comb_prev <= 1'b0;
        else        comb_prev <= comb_clk;
    end

    // Master stage follows data only while both clocks are low.
    always_ff @(posedge clk) begin
        if (!rst_n)         master_r <= 1'b0;
        else if (!comb_clk) master_r <= d;
    end

    // Slave stage: apply the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= 1'b0;
            conf_r <= 1'b0;
        end else begin
            conf_r <= (act == ACT_CONFLICT);
            case (act)
                ACT_CONFLICT: q_r <= 1'b1;
                ACT_SET:      q_r <= 1'b1;
                ACT_CLR:      q_r <= 1'b0;
                ACT_LOAD:     q_r <= master_r;
                default:      q_r <= q_r;
            endcase
        end
    end

    assign q        = q_r;
    assign qn       = ~q_r | conf_r;
    assign conflict = conf_r;

    // R5: a lone effective set drives the output high next cycle.
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_set && !eff_clr) |=> (q && !conflict));
    // R6: a lone effective clear drives the output low next cycle.
    assert_clr_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_clr && !eff_set) |=> (!q && qn));
    // R7: both forces give both outputs high plus the flag.
    assert_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_set && eff_clr) |=> (q && qn && conflict));
    // R4: nothing active means the output is unchanged.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!eff_set && !eff_clr && !(comb_clk && !comb_prev)) |=> $stable(q));
    // R3: a clock rising while the other is high is no edge.
    assert_no_double_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_prev && !eff_set && !eff_clr) |=> $stable(q));
    // R2: master content is frozen while the combined clock is high.
    assert_master_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        comb_clk |=> $stable(master_r));
endmodule

// File: rtl/tri_store.sv
// Module: top of the triple storage block. Synchronises all pins and
// instantiates one cell per element; shared pins fan out to every cell.
// Assumes: pins are asynchronous to clk and change slower than clk.
module tri_store #(
    parameter int N_ELEM      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ELEM-1:0] d_i,
    input  logic [N_ELEM-1:0] cp_i,
    input  logic [N_ELEM-1:0] set_i,
    input  logic [N_ELEM-1:0] clr_i,
    input  logic              cp_all_i,
    input  logic              set_all_i,
    input  logic              clr_all_i,
    output logic [N_ELEM-1:0] q_o,
    output logic [N_ELEM-1:0] qn_o,
    output logic [N_ELEM-1:0] conflict_o
);
    localparam int PIN_W = 4 * N_ELEM + 3;

    logic [PIN_W-1:0]  raw_pins, sync_pins;
    logic [N_ELEM-1:0] s_d, s_cp, s_set, s_clr;
    logic              s_cp_all, s_set_all, s_clr_all;

    assign raw_pins = {clr_all_i, set_all_i, cp_all_i, clr_i, set_i, cp_i, d_i};

    tri_store_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_pins),
        .dout (sync_pins)
    );

    assign {s_clr_all, s_set_all, s_cp_all, s_clr, s_set, s_cp, s_d} = sync_pins;

    for (genvar n = 0; n < N_ELEM; n++) begin : g_elem
        tri_store_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .d         (s_d[n]),
            .cp_own    (s_cp[n]),
            .cp_shared (s_cp_all),
            .set_own   (s_set[n]),
            .set_shared(s_set_all),
            .clr_own   (s_clr[n]),
            .clr_shared(s_clr_all),
            .q         (q_o[n]),
            .qn        (qn_o[n]),
            .conflict  (conflict_o[n])
        );

        // R9: without a conflict the outputs are complementary.
        assert_complement_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !conflict_o[n] |-> (q_o[n] != qn_o[n]));
    end

    // R1: one cycle of reset leaves every element cleared.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (q_o == '0 && conflict_o == '0));
endmodule

// File: tb/tri_store_tb.sv
module tri_store_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] d_i = '0, cp_i = '0, set_i = '0, clr_i = '0;
    logic cp_all_i = 1'b0, set_all_i = 1'b0, clr_all_i = 1'b0;
    logic [N-1:0] q_o, qn_o, conflict_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_store u_dut (
        .clk(clk), .rst_n(rst_n), .d_i(d_i), .cp_i(cp_i), .set_i(set_i),
        .clr_i(clr_i), .cp_all_i(cp_all_i), .set_all_i(set_all_i),
        .clr_all_i(clr_all_i), .q_o(q_o), .qn_o(qn_o), .conflict_o(conflict_o)
    );

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [N-1:0] eq, input logic [N-1:0] ec);
        logic [N-1:0] eqn;
        eqn = ~eq | ec;
        checks++;
        if (q_o !== eq || qn_o !== eqn || conflict_o !== ec) begin
            errors++;
            $display("FAIL %s: q=%b qn=%b conf=%b expected q=%b qn=%b conf=%b",
                     req, q_o, qn_o, conflict_o, eq, eqn, ec);
        end
    endtask

    // Bring all elements to zero through the master clear.
    task automatic clear_all();
        clr_all_i = 1'b1; settle();
        clr_all_i = 1'b0; settle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] ref_q;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", 3'b000, 3'b000);
        rst_n = 1'b1;
        settle();
        check("R1 after release", 3'b000, 3'b000);

        // R2: all data patterns through private clocks, then common clock
        for (int src = 0; src < 2; src++) begin
            for (int p = 0; p < 8; p++) begin
                d_i = p[N-1:0]; settle();
                if (src == 0) cp_i = '1; else cp_all_i = 1'b1;
                settle();
                check(src == 0 ? "R2 own clock load" : "R2 common clock load", p[N-1:0], '0);
                cp_i = '0; cp_all_i = 1'b0; settle();
            end
        end
        ref_q = 3'b111;

        // R4: data change without clock is ignored
        d_i = 3'b010; settle();
        check("R4 hold on data change", ref_q, '0);

        // R2: private clock of element 1 only loads element 1
        cp_i = 3'b010; settle();
        ref_q = 3'b111 & ~3'b001 & ~3'b100 | 3'b101; // elem1 gets 1, others keep 1
        check("R2 single element load", 3'b111, '0);
        cp_i = '0; d_i = 3'b000; settle();
        cp_i = 3'b010; settle();
        check("R2 single element load zero", 3'b101, '0);
        cp_i = '0; settle();

        // R3: overlapping clocks, second rise does not load
        d_i = 3'b111; settle();
        cp_all_i = 1'b1; settle();
        check("R3 common rise loads", 3'b111, '0);
        d_i = 3'b000; settle();
        cp_i = 3'b001; settle();
        check("R3 own rise under high common", 3'b111, '0);
        cp_all_i = 1'b0; settle();
        check("R3 common fall while own high", 3'b111, '0);
        cp_i = '0; settle();
        cp_i = 3'b001; settle();
        check("R3 fresh rise loads", 3'b110, '0);
        cp_i = '0; settle();

        // R10: latency of exactly three system clock edges
        d_i = 3'b111; settle();
        cp_all_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 not yet after two edges", 3'b110, '0);
        @(negedge clk);
        check("R10 visible after third edge", 3'b111, '0);
        cp_all_i = 1'b0; settle();

        // R8: force held across a clock edge, released while clock high
        clear_all();
        d_i = 3'b001; settle();
        clr_i = 3'b001; settle();
        cp_i = 3'b001; settle();
        check("R8 clear beats clock edge", 3'b000, '0);
        clr_i = '0; settle();
        check("R8 release with clock high loads nothing", 3'b000, '0);
        cp_i = '0; settle();
        cp_i = 3'b001; settle();
        check("R8 next rise loads", 3'b001, '0);
        cp_i = '0; settle();

        // R5 R6 R7: every force combination on every element
        for (int e = 0; e < N; e++) begin
            for (int c = 0; c < 16; c++) begin
                logic [N-1:0] eq, ec, hq;
                clear_all();
                set_i = '0; clr_i = '0;
                set_i[e] = c[0]; clr_i[e] = c[1];
                set_all_i = c[2]; clr_all_i = c[3];
                eq = '0; ec = '0;
                for (int j = 0; j < N; j++) begin
                    logic es, ecl;
                    es  = ((j == e) && c[0]) || c[2];
                    ecl = ((j == e) && c[1]) || c[3];
                    if (es && ecl) begin eq[j] = 1'b1; ec[j] = 1'b1; end
                    else if (es) eq[j] = 1'b1;
                    else eq[j] = 1'b0;
                end
                settle();
                check("R5 R6 R7 force sweep", eq, ec);
                hq = eq;
                set_i = '0; clr_i = '0; set_all_i = 1'b0; clr_all_i = 1'b0;
                settle();
                check("R7 R9 after force release", hq, '0);
            end
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule